// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is a slave on a two-wire serial bus (clock plus open-drain data). Both lines are oversampled by the system clock. The block frames transfers by watching for START, STOP and repeated START conditions. It answers only to one fixed 7-bit device address, and it acknowledges the bytes it receives by pulling SDA low through an output enable. Behind the bus sits a six-byte register file, reached through a byte pointer that advances on its own after each byte.

In a write transfer, the first byte after the address sets the pointer, and every byte after that is stored and acknowledged. A read transfer starts wherever the pointer was left, even by an earlier transaction, and the pointer steps from the last register back to the first. A parallel port gives local logic direct read and write access to the same registers. The last register holds charger control: it is decoded into an enable, a diode select and a resistor select, and it reports enabled only when a fixed 4-bit key sits in its upper nibble. While a write-protect input is high, the slave stays off the bus.

Top module: `twi_regport`

## Requirements
- R1: After reset, `sda_oe` is 0, all six registers read 0 on the parallel port, and `chg_en` is 0.
- R2: The slave acknowledges (holds SDA low through the ninth clock) only an address byte whose upper seven bits equal 1101000. Bit 0 of the address byte selects the direction: 0 is write, 1 is read. On any other address the slave drives nothing until the next START.
- R3: While `wp_i` is 1 when the address byte completes, the address is not acknowledged.
- R4: In a write, the byte after the address loads the pointer. Values 0 to 5 load as given; any larger value loads 0. Each later byte is stored at the pointer and acknowledged.
- R5: The pointer advances by one after every data byte, steps from 5 back to 0, and keeps its value across transactions.
- R6: A read returns bytes MSB first, starting at the pointer value held when the address was acknowledged.
- R7: A read ends when the master answers a byte with NACK (SDA high on the ninth clock). After that the slave leaves SDA released for any further clocks until the next START.
- R8: A repeated START aborts the current transfer and begins a new address phase, so a pointer write followed by a repeated START and a read address returns data from the new pointer.
- R9: The parallel port reads any register combinationally through `pp_rdata` and writes it when `pp_we` is 1. Addresses 6 and 7 read 0 and ignore writes. Values written over the bus are visible on the port, and values written through the port are visible over the bus.
- R10: The charger decode uses register 5. `chg_en` is 1 only when bits 7:4 are 1010, bits 3:2 are 01 or 10, and bits 1:0 are not 00. `chg_diode` is 1 when enabled with bits 3:2 equal to 10. `chg_rsel` equals bits 1:0 when enabled and 00 otherwise.
- R11: After a STOP condition, `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| wp_i | input | 1 | Write protect; when 1 the address is not acknowledged |
| pp_addr | input | 3 | Parallel port register index |
| pp_we | input | 1 | Parallel port write strobe |
| pp_wdata | input | 8 | Parallel port write data |
| pp_rdata | output | 8 | Parallel port read data |
| chg_en | output | 1 | Charger enabled by a valid key and selects |
| chg_diode | output | 1 | Charger path with diode |
| chg_rsel | output | 2 | Charger resistor select (00 when disabled) |

## Verification
The properties assume a well-behaved master: SDA moves only while SCL is low, except to form START and STOP. Each SCL phase lasts several system clocks longer than the synchroniser delay. The master never issues START or STOP while the slave is pulling SDA low. The bench master holds each quarter bit for eight system clocks and changes its data line only in the middle of the low phase. It models the wired-AND of both drivers, and it issues STOP or repeated START only after the slave has released the line at the end of an acknowledge or NACK.

// File: rtl/twi_regport.sv
module twi_regport #(
  parameter logic [6:0] DEV_ADDR = 7'b1101000,
  parameter int NREG = 6,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          wp_i,
  input  logic [AW-1:0] pp_addr,
  input  logic          pp_we,
  input  logic [7:0]    pp_wdata,
  output logic [7:0]    pp_rdata,
  output logic          chg_en,
  output logic          chg_diode,
  output logic [1:0]    chg_rsel
);
  localparam int PW = $clog2(NREG);
  localparam logic [2:0] ST_IDLE = 3'd0, ST_RX = 3'd1, ST_RXACK = 3'd2,
                         ST_TX = 3'd3, ST_TXACK = 3'd4;

  logic [1:0] scl_m, sda_m;
  logic scl_s, sda_s, scl_q, sda_q;
  logic start_det, stop_det, scl_rise, scl_fall;
  logic [2:0] st;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic in_addr, need_ptr, rw, mack;
  logic [PW-1:0] ptr;
  logic [7:0] regs [NREG];
  logic [7:0] tx_byte, trk;
  logic bus_we;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(NREG-1)) ? '0 : p + 1'b1;
  endfunction

  assign scl_s = scl_m[1];
  assign sda_s = sda_m[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_m <= 2'b11; sda_m <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;

  assign tx_byte = regs[ptr];
  assign bus_we  = (st == ST_RX) && scl_fall && (bitcnt == 4'd8) && !in_addr && !need_ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; in_addr <= 1'b0;
      need_ptr <= 1'b0; rw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0; ptr <= '0;
    end else if (start_det) begin
      st <= ST_RX; bitcnt <= '0; in_addr <= 1'b1; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE; in_addr <= 1'b0; sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          if (scl_fall && bitcnt == 4'd8) begin
            if (in_addr) begin
              if (shreg[7:1] == DEV_ADDR && !wp_i) begin
                sda_oe <= 1'b1; st <= ST_RXACK;
                rw <= shreg[0]; need_ptr <= ~shreg[0];
              end else begin
                st <= ST_IDLE; in_addr <= 1'b0;
              end
            end else begin
              if (need_ptr) begin
                ptr <= (shreg < 8'(NREG)) ? shreg[PW-1:0] : '0;
                need_ptr <= 1'b0;
              end else begin
                ptr <= nxt(ptr);
              end
              sda_oe <= 1'b1; st <= ST_RXACK;
            end
          end
        end
        ST_RXACK: if (scl_fall) begin
          in_addr <= 1'b0; bitcnt <= '0;
          if (rw) begin
            shreg <= tx_byte; sda_oe <= ~tx_byte[7]; ptr <= nxt(ptr); st <= ST_TX;
          end else begin
            sda_oe <= 1'b0; st <= ST_RX;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bitcnt == 4'd7) begin
            sda_oe <= 1'b0; st <= ST_TXACK;
          end else begin
            shreg <= {shreg[6:0], 1'b0}; sda_oe <= ~shreg[6]; bitcnt <= bitcnt + 4'd1;
          end
        end
        ST_TXACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              bitcnt <= '0; shreg <= tx_byte; sda_oe <= ~tx_byte[7];
              ptr <= nxt(ptr); st <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (pp_we && pp_addr == AW'(i)) regs[i] <= pp_wdata;
        else if (bus_we && ptr == PW'(i)) regs[i] <= shreg;
    end

  assign pp_rdata = (pp_addr < AW'(NREG)) ? regs[pp_addr[PW-1:0]] : 8'h00;

  assign trk       = regs[NREG-1];
  assign chg_en    = (trk[7:4] == 4'b1010) && (trk[3:2] == 2'b01 || trk[3:2] == 2'b10)
                     && (trk[1:0] != 2'b00);
  assign chg_diode = chg_en && (trk[3:2] == 2'b10);
  assign chg_rsel  = chg_en ? trk[1:0] : 2'b00;
endmodule

// File: rtl/twi_regport_chk.sv
module twi_regport_chk #(
  parameter int NREG = 6,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_det,
  input logic          stop_det,
  input logic          sda_oe,
  input logic          in_addr,
  input logic          wp_i,
  input logic [PW-1:0] ptr,
  input logic          bus_we,
  input logic          pp_we,
  input logic          chg_en
);
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R11
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe); // R8
  AST_WP_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && in_addr) |-> !$past(wp_i)); // R3
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PW'(NREG)); // R5
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R6
  AST_CHG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pp_we && !bus_we) |=> $stable(chg_en)); // R10
endmodule

bind twi_regport twi_regport_chk #(.NREG(NREG), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .in_addr(in_addr), .wp_i(wp_i),
  .ptr(ptr), .bus_we(bus_we), .pp_we(pp_we), .chg_en(chg_en)
);

// File: tb/sim_twi_regport.sv
module sim_twi_regport;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, m_low = 1'b0, wp = 1'b0;
  logic [2:0] pp_addr = '0;
  logic pp_we = 1'b0;
  logic [7:0] pp_wdata = '0;
  logic sda_oe, chg_en, chg_diode;
  logic [7:0] pp_rdata;
  logic [1:0] chg_rsel;
  logic sda_bus;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  assign sda_bus = ~(m_low | sda_oe);

  twi_regport u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .wp_i(wp), .pp_addr(pp_addr), .pp_we(pp_we), .pp_wdata(pp_wdata),
    .pp_rdata(pp_rdata), .chg_en(chg_en), .chg_diode(chg_diode), .chg_rsel(chg_rsel)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_start();
    m_low = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_stop();
    m_low = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
  endtask

  task automatic bit_x(input logic v, output logic s);
    m_low = ~v; tick(Q); scl_m = 1'b1; tick(Q);
    s = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], s);
    bit_x(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input bit give_ack, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, s); d[i] = s; end
    bit_x(~give_ack, s);
    exp_q.push_back(exp); tag_q.push_back(tag); got_q.push_back(d);
  endtask

  task automatic pp_wr(input logic [2:0] a, input logic [7:0] d);
    pp_addr = a; pp_wdata = d; pp_we = 1'b1; tick(1); pp_we = 1'b0;
  endtask

  task automatic pp_chk(input logic [2:0] a, input logic [7:0] e, input string req);
    pp_addr = a; #1;
    chk(pp_rdata === e, req, "port read", pp_rdata, e);
  endtask

  task automatic chg_chk(input logic en, input logic dio, input logic [1:0] rs);
    tick(2);
    chk({chg_en, chg_diode, chg_rsel} === {en, dio, rs}, "R10", "charger decode",
        {chg_en, chg_diode, chg_rsel}, {en, dio, rs});
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected read byte", g, 0);
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(g === e, t, "read byte", g, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : driver
    logic ack;
    tick(5);
    chk(sda_oe === 1'b0, "R1", "oe in reset", sda_oe, 0);
    chk(chg_en === 1'b0, "R1", "chg in reset", chg_en, 0);
    rst_n = 1'b1; tick(5);
    for (int i = 0; i < 6; i++) pp_chk(3'(i), 8'h00, "R1");

    // R4 R5: write pointer 2, five bytes, last wraps to 0
    do_start();
    wr_byte(8'hD0, ack); chk(ack, "R2", "address ack", ack, 1);
    wr_byte(8'h02, ack); chk(ack, "R4", "pointer ack", ack, 1);
    wr_byte(8'h11, ack); chk(ack, "R4", "data ack", ack, 1);
    wr_byte(8'h22, ack);
    wr_byte(8'h33, ack);
    wr_byte(8'h44, ack);
    wr_byte(8'h55, ack); chk(ack, "R5", "wrapped data ack", ack, 1);
    do_stop();
    chk(sda_oe === 1'b0, "R11", "oe after stop", sda_oe, 0);
    pp_chk(3'd2, 8'h11, "R4"); pp_chk(3'd5, 8'h44, "R4");
    pp_chk(3'd0, 8'h55, "R5"); pp_chk(3'd1, 8'h00, "R5");

    // R6: read from persisted pointer 1
    do_start();
    wr_byte(8'hD1, ack); chk(ack, "R2", "read address ack", ack, 1);
    rd_byte(1, 8'h00, "R6"); rd_byte(1, 8'h11, "R6"); rd_byte(0, 8'h22, "R6");
    do_stop();
    do_start();
    wr_byte(8'hD1, ack);
    rd_byte(0, 8'h33, "R5");
    do_stop();

    // R8: pointer write then repeated START read; R5 wrap; R7 release after NACK
    do_start();
    wr_byte(8'hD0, ack); wr_byte(8'h05, ack);
    do_start();
    wr_byte(8'hD1, ack); chk(ack, "R8", "address ack after repeated start", ack, 1);
    rd_byte(1, 8'h44, "R8"); rd_byte(0, 8'h55, "R5");
    rd_byte(0, 8'hFF, "R7");
    chk(sda_oe === 1'b0, "R7", "oe after nack", sda_oe, 0);
    do_stop();

    // R2: foreign address ignored
    do_start();
    wr_byte(8'hA0, ack); chk(!ack, "R2", "foreign address nack", ack, 0);
    wr_byte(8'h00, ack); chk(!ack, "R2", "no ack after foreign address", ack, 0);
    do_stop();

    // R3: write protect
    wp = 1'b1;
    do_start();
    wr_byte(8'hD0, ack); chk(!ack, "R3", "address nack under protect", ack, 0);
    do_stop();
    wp = 1'b0;

    // R4: out-of-range pointer loads 0
    do_start();
    wr_byte(8'hD0, ack); wr_byte(8'h09, ack); wr_byte(8'h77, ack);
    do_stop();
    pp_chk(3'd0, 8'h77, "R4");

    // R10 decode via port
    pp_wr(3'd5, 8'hA9); chg_chk(1, 1, 2'b01);
    pp_wr(3'd5, 8'hA6); chg_chk(1, 0, 2'b10);
    pp_wr(3'd5, 8'hAD); chg_chk(0, 0, 2'b00);
    pp_wr(3'd5, 8'hA4); chg_chk(0, 0, 2'b00);
    pp_wr(3'd5, 8'hB9); chg_chk(0, 0, 2'b00);

    // R9: out-of-range port write ignored, port write seen on bus
    pp_wr(3'd6, 8'hEE);
    pp_chk(3'd6, 8'h00, "R9"); pp_chk(3'd0, 8'h77, "R9");
    pp_wr(3'd5, 8'hA9);
    do_start();
    wr_byte(8'hD0, ack); wr_byte(8'h05, ack);
    do_start();
    wr_byte(8'hD1, ack); rd_byte(0, 8'hA9, "R9");
    do_stop();

    // R10 via bus write
    do_start();
    wr_byte(8'hD0, ack); wr_byte(8'h05, ack); wr_byte(8'hAB, ack);
    do_stop();
    chg_chk(1, 1, 2'b11);

    tick(20);
    chk(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule